// File: doc/BRIEF.md
# Clock-Crossing FIFO with Spill Recovery

This block moves data words from a write clock domain into a transmit clock domain through a dual-clock FIFO. The write side offers a clock-enable style write strobe with a full flag. The transmit side offers a read enable, a registered data output with a valid flag, and an empty flag. Both pointers cross between the domains as Gray code through synchroniser chains, and each keeps one extra wrap bit so that full and empty can be told apart.

A spill is a write into a full FIFO (overflow) or a read from an empty FIFO (underflow). Either one sets a sticky status bit in the transmit domain. That bit drives an interrupt unless the interrupt is masked. A write-one-to-clear strobe clears the bit, but a spill in the same cycle wins. Overflows are detected in the write domain and carried across by a toggle synchroniser, so the transmit domain sees each one once.

Recovery is configurable. With automatic recovery off, a spill only updates the status. With it on, a select input picks between two actions. One is a one-cycle realignment request sent upstream. The other is a pointer reset that restarts the FIFO centred, with the read pointer half the depth behind the write pointer. A lock-qualify input can make recovery depend on a lock indication. An external request also triggers the pointer reset. The reset completes through a handshake between the domains. Until it completes, reads and writes are ignored and are not counted as spills. The intended tie-off values are automatic recovery off and the interrupt masked.

Top module: `spill_fifo`

## Requirements
- R1: Words come out of `rd_data` in write order. For a read accepted at a transmit clock edge (`rd_en` high, `rd_empty` low), `rd_data` holds the word and `rd_valid` is high after that same edge.
- R2: After reset, `rd_empty` is 1 and `wr_full` is 0. `wr_full` rises once DEPTH words have been written and none read. `rd_empty` is 1 again once every written word has been read.
- R3: A write while `wr_full` is high is dropped. It leaves the stored words unchanged and counts as a spill.
- R4: A read while `rd_empty` is high returns no word (`rd_valid` stays 0) and counts as a spill.
- R5: `spill_status` is set after the edge at which a spill is seen. It stays set until a cycle with `status_clr` high and no spill. A spill in the same cycle as `status_clr` keeps it set. `spill_irq` equals `spill_status` while `irq_mask` is 0 and is 0 while `irq_mask` is 1.
- R6: With `cfg_auto_en` low, a spill raises no `realign_req` and leaves the pointers unchanged.
- R7: With `cfg_auto_en` and `cfg_sel_realign` high, each spill raises `realign_req` for exactly one transmit cycle and leaves the pointers unchanged.
- R8: With `cfg_auto_en` high and `cfg_sel_realign` low, a spill raises no `realign_req`. It resets the pointers, after which the FIFO holds DEPTH/2 readable words.
- R9: With `cfg_lock_qual` high, automatic recovery happens only while `lock_in` is 1. With `cfg_lock_qual` low, `lock_in` has no effect.
- R10: A pulse on `ext_ptr_rst` resets the pointers as in R8, whatever the configuration. It does not set `spill_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst_n | input | 1 | Write domain asynchronous reset, active low |
| wr_en | input | 1 | Write strobe (clock enable for the write port) |
| wr_data | input | WIDTH | Word to write |
| wr_full | output | 1 | FIFO full, seen from the write domain |
| tx_clk | input | 1 | Transmit domain clock |
| tx_rst_n | input | 1 | Transmit domain asynchronous reset, active low |
| rd_en | input | 1 | Read enable |
| rd_data | output | WIDTH | Registered read word |
| rd_valid | output | 1 | `rd_data` holds a word read at the last edge |
| rd_empty | output | 1 | FIFO empty, seen from the transmit domain |
| cfg_auto_en | input | 1 | Enable automatic recovery on a spill |
| cfg_sel_realign | input | 1 | 1: send a realignment request; 0: reset the pointers |
| cfg_lock_qual | input | 1 | Require `lock_in` for automatic recovery |
| lock_in | input | 1 | Lock indication |
| irq_mask | input | 1 | Suppress `spill_irq` |
| ext_ptr_rst | input | 1 | External pointer reset request |
| status_clr | input | 1 | Write-one-to-clear strobe for `spill_status` |
| spill_status | output | 1 | Sticky spill indication |
| spill_irq | output | 1 | Interrupt: status and not masked |
| realign_req | output | 1 | One-cycle realignment request to upstream |

## Verification
The case hardest to reach from the ports is recovery through the pointer reset. The spill must first cross domains, or be made on the transmit side, and the outcome only shows after the reset handshake has gone to the write domain and back. The bench forces it in two ways: a read from an empty FIFO, and a write beyond a full FIFO that is carried across as a toggled event. It then waits out the handshake. It proves the centred restart by reading exactly DEPTH/2 valid words and then finding the FIFO empty. A sweep over every fill level from one word to DEPTH checks order and flags, and each policy setting is driven with a spill whose realignment pulses are counted.

// File: rtl/spill_fifo_pkg.sv
package spill_fifo_pkg;
   // Transmit-side pointer reset progress
   typedef enum logic [1:0] {
      PR_IDLE     = 2'd0,
      PR_WAIT_ACK = 2'd1,
      PR_TAIL     = 2'd2
   } prst_state_e;

   typedef struct packed {
      logic auto_en;
      logic sel_realign;
      logic lock_qual;
   } spill_cfg_t;
endpackage

// File: rtl/spill_sync.sv
module spill_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spill_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spill_pulse_xing.sv
module spill_pulse_xing #(
   parameter int STAGES = 2
) (
   input  logic src_clk,
   input  logic src_rst_n,
   input  logic src_pulse,
   input  logic dst_clk,
   input  logic dst_rst_n,
   output logic dst_pulse
);
   logic tog, tog_s, tog_d;

   always_ff @(posedge src_clk or negedge src_rst_n) begin
      if (!src_rst_n)     tog <= 1'b0;
      else if (src_pulse) tog <= ~tog;
   end

   spill_sync #(.WIDTH(1), .STAGES(STAGES)) u_sync (
      .clk(dst_clk), .rst_n(dst_rst_n), .d(tog), .q(tog_s)
   );

   always_ff @(posedge dst_clk or negedge dst_rst_n) begin
      if (!dst_rst_n) tog_d <= 1'b0;
      else            tog_d <= tog_s;
   end

   assign dst_pulse = tog_s ^ tog_d;
endmodule

// File: rtl/spill_policy.sv
module spill_policy
   import spill_fifo_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       spill,
   input  spill_cfg_t cfg,
   input  logic       lock_in,
   input  logic       irq_mask,
   input  logic       status_clr,
   input  logic       ext_rst,
   input  logic       busy,
   output logic       status,
   output logic       irq,
   output logic       realign_req,
   output logic       prst_go
);
   logic qualified;
   assign qualified = cfg.auto_en & (~cfg.lock_qual | lock_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status      <= 1'b0;
         realign_req <= 1'b0;
      end else begin
         realign_req <= spill & qualified & cfg.sel_realign;
         if (spill)           status <= 1'b1;
         else if (status_clr) status <= 1'b0;
      end
   end

   assign prst_go = ~busy & (ext_rst | (spill & qualified & ~cfg.sel_realign));
   assign irq     = status & ~irq_mask;

   a_r5_spill_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
      spill |=> status);
   a_r5_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status && !status_clr) |=> status);
   a_r6_realign_needs_auto: assert property (@(posedge clk) disable iff (!rst_n)
      realign_req |-> $past(cfg.auto_en && cfg.sel_realign && spill));
   a_r9_realign_lock_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      realign_req |-> $past(!cfg.lock_qual || lock_in));
endmodule

// File: rtl/spill_fifo.sv
module spill_fifo
   import spill_fifo_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             wr_clk,
   input  logic             wr_rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic             wr_full,
   input  logic             tx_clk,
   input  logic             tx_rst_n,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_valid,
   output logic             rd_empty,
   input  logic             cfg_auto_en,
   input  logic             cfg_sel_realign,
   input  logic             cfg_lock_qual,
   input  logic             lock_in,
   input  logic             irq_mask,
   input  logic             ext_ptr_rst,
   input  logic             status_clr,
   output logic             spill_status,
   output logic             spill_irq,
   output logic             realign_req
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;
   localparam logic [PW-1:0] HALF_B = PW'(DEPTH / 2);
   localparam logic [PW-1:0] HALF_G = HALF_B ^ (HALF_B >> 1);

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("spill_fifo: DEPTH must be a power of two, at least 4");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("spill_fifo: WIDTH must be positive");
      end
   endgenerate

   function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
      return b ^ (b >> 1);
   endfunction

   logic [WIDTH-1:0] mem [DEPTH];

   // ---------------- write domain ----------------
   logic [PW-1:0] wbin, wgray, rgray_s;
   logic [1:0]    wbusy;
   logic          wrst_go, wr_fire, ovf;

   assign wr_full = (wgray == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
   assign wr_fire = wr_en & ~wr_full & (wbusy == 2'd0) & ~wrst_go;
   assign ovf     = wr_en &  wr_full & (wbusy == 2'd0) & ~wrst_go;

   always_ff @(posedge wr_clk or negedge wr_rst_n) begin
      if (!wr_rst_n) begin
         wbin  <= '0;
         wgray <= '0;
         wbusy <= 2'd0;
      end else if (wrst_go) begin
         wbin  <= HALF_B;
         wgray <= HALF_G;
         wbusy <= 2'd2;
      end else begin
         if (wbusy != 2'd0) wbusy <= wbusy - 2'd1;
         if (wr_fire) begin
            wbin  <= wbin + PW'(1);
            wgray <= to_gray(wbin + PW'(1));
         end
      end
   end

   always_ff @(posedge wr_clk) begin
      if (wr_fire) mem[wbin[AW-1:0]] <= wr_data;
   end

   spill_sync #(.WIDTH(PW), .STAGES(STAGES)) u_rptr_sync (
      .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_s)
   );

   a_r3_full_holds_wptr: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (wr_full && !wrst_go) |=> $stable(wbin));

   // ---------------- transmit domain ----------------
   logic [PW-1:0] rbin, rgray, wgray_s;
   prst_state_e   pr_state;
   logic          ovf_evt, ack_evt, prst_go, rd_fire, udf, spill, idle;
   spill_cfg_t    cfg;

   assign cfg      = '{auto_en: cfg_auto_en, sel_realign: cfg_sel_realign,
                       lock_qual: cfg_lock_qual};
   assign idle     = (pr_state == PR_IDLE);
   assign rd_empty = (rgray == wgray_s);
   assign udf      = rd_en & rd_empty & idle;
   assign spill    = idle & (udf | ovf_evt);
   assign rd_fire  = rd_en & ~rd_empty & idle & ~prst_go;

   always_ff @(posedge tx_clk or negedge tx_rst_n) begin
      if (!tx_rst_n) begin
         rbin     <= '0;
         rgray    <= '0;
         pr_state <= PR_IDLE;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_fire;
         unique case (pr_state)
            PR_IDLE: begin
               if (prst_go) begin
                  rbin     <= '0;
                  rgray    <= '0;
                  pr_state <= PR_WAIT_ACK;
               end else if (rd_fire) begin
                  rbin  <= rbin + PW'(1);
                  rgray <= to_gray(rbin + PW'(1));
               end
            end
            PR_WAIT_ACK: if (ack_evt) pr_state <= PR_TAIL;
            default:     pr_state <= PR_IDLE;
         endcase
      end
   end

   always_ff @(posedge tx_clk) begin
      if (rd_fire) rd_data <= mem[rbin[AW-1:0]];
   end

   spill_sync #(.WIDTH(PW), .STAGES(STAGES)) u_wptr_sync (
      .clk(tx_clk), .rst_n(tx_rst_n), .d(wgray), .q(wgray_s)
   );

   spill_pulse_xing #(.STAGES(STAGES)) u_ovf_xing (
      .src_clk(wr_clk), .src_rst_n(wr_rst_n), .src_pulse(ovf),
      .dst_clk(tx_clk), .dst_rst_n(tx_rst_n), .dst_pulse(ovf_evt)
   );

   spill_pulse_xing #(.STAGES(STAGES)) u_prst_xing (
      .src_clk(tx_clk), .src_rst_n(tx_rst_n), .src_pulse(prst_go),
      .dst_clk(wr_clk), .dst_rst_n(wr_rst_n), .dst_pulse(wrst_go)
   );

   spill_pulse_xing #(.STAGES(STAGES)) u_ack_xing (
      .src_clk(wr_clk), .src_rst_n(wr_rst_n), .src_pulse(wrst_go),
      .dst_clk(tx_clk), .dst_rst_n(tx_rst_n), .dst_pulse(ack_evt)
   );

   spill_policy u_policy (
      .clk(tx_clk), .rst_n(tx_rst_n), .spill(spill), .cfg(cfg),
      .lock_in(lock_in), .irq_mask(irq_mask), .status_clr(status_clr),
      .ext_rst(ext_ptr_rst), .busy(~idle), .status(spill_status),
      .irq(spill_irq), .realign_req(realign_req), .prst_go(prst_go)
   );

   a_r4_empty_holds_rptr: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
      (rd_empty && !prst_go) |=> ($stable(rbin) && !rd_valid));
   a_r8_reset_restarts_read: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
      prst_go |=> (rbin == '0 && !rd_valid));
endmodule

// File: tb/test_spill_fifo.sv
module test_spill_fifo;
   localparam int DEPTH = 8;
   localparam int WIDTH = 8;
   localparam int HALF  = DEPTH / 2;

   logic wr_clk = 1'b0, tx_clk = 1'b0;
   logic wr_rst_n = 1'b0, tx_rst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [WIDTH-1:0] wr_data = '0;
   logic wr_full, rd_valid, rd_empty;
   logic [WIDTH-1:0] rd_data;
   logic cfg_auto_en = 1'b0, cfg_sel_realign = 1'b0, cfg_lock_qual = 1'b0;
   logic lock_in = 1'b0, irq_mask = 1'b1, ext_ptr_rst = 1'b0, status_clr = 1'b0;
   logic spill_status, spill_irq, realign_req;

   int errors = 0, checks = 0, pulses = 0;
   bit done = 1'b0;

   always #5 tx_clk = ~tx_clk;   // 100 MHz transmit clock
   always #7 wr_clk = ~wr_clk;

   spill_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .STAGES(2)) i_spill_fifo (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wr_full(wr_full), .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .rd_en(rd_en),
      .rd_data(rd_data), .rd_valid(rd_valid), .rd_empty(rd_empty),
      .cfg_auto_en(cfg_auto_en), .cfg_sel_realign(cfg_sel_realign),
      .cfg_lock_qual(cfg_lock_qual), .lock_in(lock_in), .irq_mask(irq_mask),
      .ext_ptr_rst(ext_ptr_rst), .status_clr(status_clr),
      .spill_status(spill_status), .spill_irq(spill_irq), .realign_req(realign_req)
   );

   always @(posedge tx_clk) if (realign_req) pulses <= pulses + 1;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tx_wait(input int n);
      repeat (n) @(negedge tx_clk);
   endtask

   task automatic wr_wait(input int n);
      repeat (n) @(negedge wr_clk);
   endtask

   task automatic put(input logic [WIDTH-1:0] d);
      @(negedge wr_clk); wr_en = 1'b1; wr_data = d;
      @(negedge wr_clk); wr_en = 1'b0;
   endtask

   task automatic take(output logic v, output logic [WIDTH-1:0] d);
      @(negedge tx_clk); rd_en = 1'b1;
      @(negedge tx_clk); rd_en = 1'b0;
      v = rd_valid; d = rd_data;
   endtask

   task automatic clear_status();
      @(negedge tx_clk); status_clr = 1'b1;
      @(negedge tx_clk); status_clr = 1'b0;
   endtask

   // read HALF words after a pointer reset and then expect empty
   task automatic expect_centred(input string tag);
      logic v; logic [WIDTH-1:0] d;
      chk({tag, " not empty after recovery"}, int'(rd_empty), 0);
      for (int i = 0; i < HALF; i++) begin
         take(v, d);
         chk({tag, " centred word valid"}, int'(v), 1);
      end
      tx_wait(1);
      chk({tag, " empty after DEPTH/2 reads"}, int'(rd_empty), 1);
   endtask

   initial begin
      logic v; logic [WIDTH-1:0] d;
      int p0;
      tx_wait(3);
      wr_rst_n = 1'b1; tx_rst_n = 1'b1;
      tx_wait(2);

      // reset state
      chk("R2 reset empty", int'(rd_empty), 1);
      chk("R2 reset not full", int'(wr_full), 0);
      chk("R5 reset status", int'(spill_status), 0);
      chk("R1 reset rd_valid", int'(rd_valid), 0);
      chk("R7 reset realign", int'(realign_req), 0);

      // sweep every fill level
      for (int n = 1; n <= DEPTH; n++) begin
         for (int i = 0; i < n; i++) put(WIDTH'(n * 16 + i));
         wr_wait(1);
         chk("R2 full flag at fill level", int'(wr_full), int'(n == DEPTH));
         tx_wait(8);
         chk("R2 not empty after writes", int'(rd_empty), 0);
         for (int i = 0; i < n; i++) begin
            take(v, d);
            chk("R1 read valid", int'(v), 1);
            chk("R1 read data order", int'(d), (n * 16 + i) % 256);
         end
         tx_wait(1);
         chk("R2 empty after draining", int'(rd_empty), 1);
         wr_wait(6);
      end
      chk("R5 no spill during sweep", int'(spill_status), 0);

      // overflow, recovery disabled
      for (int i = 0; i < DEPTH; i++) put(WIDTH'(200 + i));
      put(8'hEE);
      tx_wait(12);
      chk("R3 overflow sets status", int'(spill_status), 1);
      chk("R5 irq masked", int'(spill_irq), 0);
      chk("R6 no realign when disabled", pulses, 0);
      for (int i = 0; i < DEPTH; i++) begin
         take(v, d);
         chk("R3 stored word kept after overflow", int'(d), 200 + i);
      end
      tx_wait(1);
      chk("R3 overflow word dropped", int'(rd_empty), 1);
      wr_wait(6);

      // interrupt unmasked and clear
      irq_mask = 1'b0;
      tx_wait(1);
      chk("R5 irq follows status", int'(spill_irq), 1);
      clear_status();
      chk("R5 clear drops status", int'(spill_status), 0);
      chk("R5 clear drops irq", int'(spill_irq), 0);

      // underflow, recovery disabled
      take(v, d);
      chk("R4 underflow gives no word", int'(v), 0);
      chk("R4 underflow sets status", int'(spill_status), 1);
      tx_wait(10);
      chk("R6 pointers untouched (still empty)", int'(rd_empty), 1);
      chk("R6 no realign on underflow", pulses, 0);

      // clear coinciding with spill
      clear_status();
      @(negedge tx_clk); status_clr = 1'b1; rd_en = 1'b1;
      @(negedge tx_clk); status_clr = 1'b0; rd_en = 1'b0;
      chk("R5 spill beats same-cycle clear", int'(spill_status), 1);
      clear_status();

      // realignment selected
      cfg_auto_en = 1'b1; cfg_sel_realign = 1'b1;
      p0 = pulses;
      take(v, d);
      tx_wait(3);
      chk("R7 one realign cycle per spill", pulses - p0, 1);
      tx_wait(10);
      chk("R7 pointers untouched", int'(rd_empty), 1);
      clear_status();

      // lock qualification
      cfg_lock_qual = 1'b1; lock_in = 1'b0;
      p0 = pulses;
      take(v, d);
      tx_wait(3);
      chk("R9 no recovery without lock", pulses - p0, 0);
      chk("R9 status still set without lock", int'(spill_status), 1);
      lock_in = 1'b1;
      take(v, d);
      tx_wait(3);
      chk("R9 recovery with lock", pulses - p0, 1);
      cfg_lock_qual = 1'b0; lock_in = 1'b0;
      take(v, d);
      tx_wait(3);
      chk("R9 lock ignored when not qualifying", pulses - p0, 2);
      clear_status();

      // pointer reset selected, underflow trigger
      cfg_sel_realign = 1'b0;
      p0 = pulses;
      take(v, d);
      tx_wait(40);
      chk("R8 no realign on pointer reset", pulses - p0, 0);
      expect_centred("R8 underflow");
      clear_status();
      wr_wait(6);

      // pointer reset selected, overflow trigger
      for (int i = 0; i < DEPTH; i++) put(WIDTH'(i));
      put(8'h55);
      tx_wait(50);
      chk("R8 overflow spill flagged", int'(spill_status), 1);
      expect_centred("R8 overflow");
      clear_status();
      wr_wait(6);

      // external pointer reset, recovery disabled
      cfg_auto_en = 1'b0;
      put(8'h11); put(8'h22);
      tx_wait(8);
      @(negedge tx_clk); ext_ptr_rst = 1'b1;
      @(negedge tx_clk); ext_ptr_rst = 1'b0;
      tx_wait(40);
      chk("R10 external reset no status", int'(spill_status), 0);
      expect_centred("R10 external");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule